// File: doc/BRIEF.md
# Arithmetic/Logic Execute Stage with Immediate Operands

This block is the execute stage for the arithmetic and logic instructions of a 16-bit processor. One instruction word enters per cycle, qualified by `issue`. The block drives the two register-file read selects straight from the instruction word. The register file answers with `rd_val` (the destination register's current value) and `rs_val` (the source register's value) in the same cycle. One clock edge later the block presents a registered writeback (`wb_en`, `wb_sel`, `wb_data`), the updated carry and zero flags, and the 32-bit product register.

The block has no sequencing states, so the state-machine layout applies to a decoded instruction class. Each issued word falls into one of five classes:
- `CL_NONE`: any word outside this block's scope. It has no effect.
- `CL_ALU`: the eight arithmetic/logic operations, in register or immediate form.
- `CL_HIGH`: move-immediate-high.
- `CL_MUL`: multiply into the product register.
- `CL_PROD`: load the product register from two registers.

Every class returns to the same single issue slot on the next cycle. There are no transitions other than "decode, then commit at the edge".

The instruction fields are:
- An immediate operand is flagged by bit 7 and comes from bits 6..0.
- The move-immediate-high constant is gathered from three separate fields.
- Compare is a subtract that only writes flags.

Top module: `alu_exec`

## Requirements
- R1: `rd_sel` equals instruction bits 10..8 and `rs_sel` equals bits 2..0, combinationally.
- R2: A word with bits 15..14 = 01 is an ALU operation. Bits 13..11 select it: 000 add, 001 add-with-carry, 010 subtract, 011 AND, 100 OR, 101 XOR, 110 compare, 111 move (result = second operand). On the edge after issue, `wb_en`=1, `wb_sel`=bits 10..8 and `wb_data` holds the result, except for compare.
- R3: When bit 7 is 1, the second operand is bits 6..0 zero-extended to 16 bits. When bit 7 is 0, it is `rs_val`.
- R4: Add and add-with-carry set carry to the carry out of bit 15. Add-with-carry adds the old carry. Subtract sets carry to 1 exactly when the second operand exceeds the first (borrow). All three set zero when the 16-bit result is 0.
- R5: Compare (op 110) updates carry and zero exactly as subtract would and leaves `wb_en` at 0.
- R6: AND, OR, XOR and move update zero from their result and keep carry unchanged.
- R7: A word with bits 15..14 = 00 writes register bits 10..8 with the 11-bit constant {bits 13..11, bits 7..3, bits 2..0} shifted left by 5. Carry and zero are unchanged.
- R8: A word with bits 15..11 = 11111 and bits 7..3 = 00011 (multiply) loads `product` with the full 32-bit unsigned product `rd_val`×`rs_val`. It writes no register and leaves the flags unchanged.
- R9: A word with bits 15..11 = 11111 and bits 7..3 = 00101 loads `product` with {`rs_val`, `rd_val`}. It writes no register and leaves the flags unchanged.
- R10: With `issue` low, or for any other word, `wb_en` is 0 on the next cycle, and the flags and `product` hold.
- R11: After reset, `wb_en`, `wb_sel`, `wb_data`, both flags and `product` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| rd_sel | output | 3 | Register-file read select for the destination operand |
| rs_sel | output | 3 | Register-file read select for the source operand |
| rd_val | input | 16 | Value read from `rd_sel` |
| rs_val | input | 16 | Value read from `rs_sel` |
| wb_en | output | 1 | Writeback strobe |
| wb_sel | output | 3 | Writeback register index |
| wb_data | output | 16 | Writeback value |
| flag_c | output | 1 | Carry / borrow flag |
| flag_z | output | 1 | Zero flag |
| product | output | 32 | Product register |

## Verification
The hardest behaviour to reach from the ports is the carry chain. Add-with-carry and the carry-preserving logic operations depend on a flag left behind by an earlier instruction. The vector table is therefore walked strictly in order, with each entry's expected flags derived from the state the previous entry left. For example, a wrapping immediate add is placed just before an add-with-carry, and a borrowing subtract just before logic operations whose carry must survive. Directed tests then reach the product register through multiply and load-product words, and confirm that idle cycles and out-of-scope words change nothing visible.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

    localparam int IW     = 16;
    localparam int DW     = 16;
    localparam int RW     = 3;
    localparam int IMM_W  = 7;
    localparam int HI_W   = 11;
    localparam int HI_SH  = DW - HI_W;
    localparam int PW     = 2 * DW;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_AND = 3'd3,
        OP_OR  = 3'd4,
        OP_XOR = 3'd5,
        OP_CMP = 3'd6,
        OP_MOV = 3'd7
    } alu_op_e;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_ALU,
        CL_HIGH,
        CL_MUL,
        CL_PROD
    } ex_class_e;

    typedef struct packed {
        ex_class_e       cls;
        alu_op_e         op;
        logic            use_imm;
        logic [RW-1:0]   dst;
        logic [RW-1:0]   src;
        logic [DW-1:0]   imm;
        logic [DW-1:0]   high;
    } dec_t;

endpackage

// File: rtl/alu_exec_decode.sv
module alu_exec_decode
    import alu_exec_pkg::*;
(
    input  logic [IW-1:0] instr,
    output dec_t          dec
);

    localparam logic [4:0] SUB_MUL  = 5'b00011;
    localparam logic [4:0] SUB_PROD = 5'b00101;

    logic [HI_W-1:0] hi_k;

    always_comb begin
        hi_k         = {instr[13:11], instr[7:3], instr[2:0]};
        dec.op       = alu_op_e'(instr[13:11]);
        dec.use_imm  = instr[7];
        dec.dst      = instr[10:8];
        dec.src      = instr[2:0];
        dec.imm      = {{(DW-IMM_W){1'b0}}, instr[IMM_W-1:0]};
        dec.high     = {hi_k, {HI_SH{1'b0}}};
        dec.cls      = CL_NONE;
        unique case (instr[15:14])
            2'b00: dec.cls = CL_HIGH;
            2'b01: dec.cls = CL_ALU;
            2'b11: begin
                if (instr[13:11] == 3'b111 && instr[7:3] == SUB_MUL)
                    dec.cls = CL_MUL;
                else if (instr[13:11] == 3'b111 && instr[7:3] == SUB_PROD)
                    dec.cls = CL_PROD;
            end
            default: dec.cls = CL_NONE;
        endcase
    end

endmodule

// File: rtl/alu_exec_core.sv
module alu_exec_core
    import alu_exec_pkg::*;
(
    input  alu_op_e        op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic           cin,
    output logic [DW-1:0]  res,
    output logic           cout,
    output logic           upd_c,
    output logic           writes
);

    logic [DW:0] wide;

    always_comb begin
        wide   = '0;
        res    = '0;
        cout   = 1'b0;
        upd_c  = 1'b0;
        writes = 1'b1;
        unique case (op)
            OP_ADD: begin
                wide  = {1'b0, a} + {1'b0, b};
                upd_c = 1'b1;
            end
            OP_ADC: begin
                wide  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
                upd_c = 1'b1;
            end
            OP_SUB, OP_CMP: begin
                wide   = {1'b0, a} - {1'b0, b};
                upd_c  = 1'b1;
                writes = (op == OP_SUB);
            end
            OP_AND: wide = {1'b0, a & b};
            OP_OR:  wide = {1'b0, a | b};
            OP_XOR: wide = {1'b0, a ^ b};
            OP_MOV: wide = {1'b0, b};
            default: wide = '0;
        endcase
        res  = wide[DW-1:0];
        cout = wide[DW];
    end

endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import alu_exec_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [15:0]   instr,
    output logic [2:0]    rd_sel,
    output logic [2:0]    rs_sel,
    input  logic [15:0]   rd_val,
    input  logic [15:0]   rs_val,
    output logic          wb_en,
    output logic [2:0]    wb_sel,
    output logic [15:0]   wb_data,
    output logic          flag_c,
    output logic          flag_z,
    output logic [31:0]   product
);

    typedef struct packed {
        logic           wen;
        logic [RW-1:0]  sel;
        logic [DW-1:0]  data;
        logic           c;
        logic           z;
        logic [PW-1:0]  prod;
    } ex_state_t;

    dec_t          dec;
    logic [DW-1:0] opnd_b;
    logic [DW-1:0] alu_res;
    logic          alu_cout;
    logic          alu_updc;
    logic          alu_wr;
    ex_state_t     cur, nxt;

    alu_exec_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    assign opnd_b = dec.use_imm ? dec.imm : rs_val;

    alu_exec_core u_core (
        .op     (dec.op),
        .a      (rd_val),
        .b      (opnd_b),
        .cin    (cur.c),
        .res    (alu_res),
        .cout   (alu_cout),
        .upd_c  (alu_updc),
        .writes (alu_wr)
    );

    always_comb begin
        nxt     = cur;
        nxt.wen = 1'b0;
        if (issue) begin
            unique case (dec.cls)
                CL_ALU: begin
                    nxt.z = (alu_res == '0);
                    if (alu_updc) nxt.c = alu_cout;
                    if (alu_wr) begin
                        nxt.wen  = 1'b1;
                        nxt.sel  = dec.dst;
                        nxt.data = alu_res;
                    end
                end
                CL_HIGH: begin
                    nxt.wen  = 1'b1;
                    nxt.sel  = dec.dst;
                    nxt.data = dec.high;
                end
                CL_MUL:  nxt.prod = PW'(rd_val) * PW'(rs_val);
                CL_PROD: nxt.prod = {rs_val, rd_val};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= '0;
        else        cur <= nxt;
    end

    assign rd_sel  = dec.dst;
    assign rs_sel  = dec.src;
    assign wb_en   = cur.wen;
    assign wb_sel  = cur.sel;
    assign wb_data = cur.data;
    assign flag_c  = cur.c;
    assign flag_z  = cur.z;
    assign product = cur.prod;

endmodule

module alu_exec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        issue,
    input logic [15:0] instr,
    input logic        wb_en,
    input logic [2:0]  wb_sel,
    input logic [15:0] wb_data,
    input logic        flag_c,
    input logic        flag_z,
    input logic [31:0] product
);

    logic grp_alu, grp_high, is_cmp, is_logic;
    assign grp_alu  = instr[15:14] == 2'b01;
    assign grp_high = instr[15:14] == 2'b00;
    assign is_cmp   = grp_alu && instr[13:11] == 3'b110;
    assign is_logic = grp_alu && (instr[13:11] == 3'b011 || instr[13:11] == 3'b100 ||
                                  instr[13:11] == 3'b101 || instr[13:11] == 3'b111);

    a_r2_dest_written: assert property (@(posedge clk) disable iff (!rst_n)
        issue && (grp_high || (grp_alu && !is_cmp)) |=> wb_en && wb_sel == $past(instr[10:8]));

    a_r2_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
        issue && grp_alu && !is_cmp |=> flag_z == (wb_data == 16'd0));

    a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        issue && is_cmp |=> !wb_en);

    a_r6_logic_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        issue && is_logic |=> flag_c == $past(flag_c));

    a_r7_high_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        issue && grp_high |=> wb_data[4:0] == 5'd0 && $stable(flag_c) && $stable(flag_z));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> !wb_en && $stable(flag_c) && $stable(flag_z) && $stable(product));

endmodule

bind alu_exec alu_exec_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .instr   (instr),
    .wb_en   (wb_en),
    .wb_sel  (wb_sel),
    .wb_data (wb_data),
    .flag_c  (flag_c),
    .flag_z  (flag_z),
    .product (product)
);

// File: tb/tb_alu_exec.sv
module tb_alu_exec;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] rd_val = '0;
    logic [15:0] rs_val = '0;
    logic [2:0]  rd_sel, rs_sel, wb_sel;
    logic        wb_en, flag_c, flag_z;
    logic [15:0] wb_data;
    logic [31:0] product;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_exec dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
        .rd_sel(rd_sel), .rs_sel(rs_sel), .rd_val(rd_val), .rs_val(rs_val),
        .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data),
        .flag_c(flag_c), .flag_z(flag_z), .product(product)
    );

    function automatic logic [15:0] enc_r(input logic [2:0] op, input logic [2:0] d, input logic [2:0] s);
        return {2'b01, op, d, 5'b00000, s};
    endfunction
    function automatic logic [15:0] enc_i(input logic [2:0] op, input logic [2:0] d, input logic [6:0] k);
        return {2'b01, op, d, 1'b1, k};
    endfunction
    function automatic logic [15:0] enc_h(input logic [2:0] d, input logic [10:0] k);
        return {2'b00, k[10:8], d, k[7:0]};
    endfunction

    // entry: instr, rd_val, rs_val, exp wb_en, exp wb_data, exp C, exp Z
    typedef logic [66:0] vec_t;
    localparam vec_t VECS [NVEC] = '{
        {enc_r(3'd0,3'd1,3'd2), 16'h0003, 16'h0004, 1'b1, 16'h0007, 1'b0, 1'b0}, // R2 R4 add
        {enc_i(3'd0,3'd2,7'h7F), 16'hFFF0, 16'h1111, 1'b1, 16'h006F, 1'b1, 1'b0}, // R3 R4 addi wrap
        {enc_r(3'd1,3'd3,3'd4), 16'h0010, 16'h0020, 1'b1, 16'h0031, 1'b0, 1'b0}, // R4 adc cin=1
        {enc_i(3'd1,3'd3,7'h01), 16'hFFFE, 16'h0000, 1'b1, 16'hFFFF, 1'b0, 1'b0}, // R4 adci cin=0
        {enc_r(3'd2,3'd4,3'd5), 16'h0005, 16'h0005, 1'b1, 16'h0000, 1'b0, 1'b1}, // R4 sub zero
        {enc_i(3'd2,3'd5,7'h06), 16'h0005, 16'h0000, 1'b1, 16'hFFFF, 1'b1, 1'b0}, // R4 subi borrow
        {enc_r(3'd3,3'd6,3'd7), 16'hF0F0, 16'h0FF0, 1'b1, 16'h00F0, 1'b1, 1'b0}, // R6 and
        {enc_i(3'd4,3'd7,7'h00), 16'h0000, 16'hFFFF, 1'b1, 16'h0000, 1'b1, 1'b1}, // R6 ori zero
        {enc_r(3'd5,3'd0,3'd1), 16'hAAAA, 16'hAAAA, 1'b1, 16'h0000, 1'b1, 1'b1}, // R6 xor
        {enc_i(3'd3,3'd1,7'h40), 16'hFFC0, 16'h0000, 1'b1, 16'h0040, 1'b1, 1'b0}, // R3 zero-extend
        {enc_r(3'd6,3'd2,3'd3), 16'h0003, 16'h0009, 1'b0, 16'h0000, 1'b1, 1'b0}, // R5 cmp borrow
        {enc_i(3'd6,3'd2,7'h12), 16'h0012, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b1}, // R5 cmpi equal
        {enc_r(3'd7,3'd3,3'd4), 16'h9999, 16'h1234, 1'b1, 16'h1234, 1'b0, 1'b0}, // R6 mov
        {enc_i(3'd7,3'd4,7'h55), 16'h9999, 16'h7777, 1'b1, 16'h0055, 1'b0, 1'b0}, // R3 movi
        {enc_r(3'd2,3'd1,3'd1), 16'h0009, 16'h0009, 1'b1, 16'h0000, 1'b0, 1'b1}, // R4 sub
        {enc_h(3'd5,11'h7FF), 16'h0000, 16'h0000, 1'b1, 16'hFFE0, 1'b0, 1'b1}, // R7 flags held
        {enc_h(3'd6,11'h401), 16'h1234, 16'h0000, 1'b1, 16'h8020, 1'b0, 1'b1}, // R7 field order
        {enc_r(3'd2,3'd0,3'd1), 16'h0000, 16'h0001, 1'b1, 16'hFFFF, 1'b1, 1'b0}, // R4 borrow
        {enc_r(3'd1,3'd7,3'd6), 16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0, 1'b0}  // R4 adc carry in
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic iss, input logic [15:0] w, input logic [15:0] a, input logic [15:0] b);
        issue  = iss;
        instr  = w;
        rd_val = a;
        rs_val = b;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        #(CLK_PERIOD * 2 + 1);
        check("R11 wb_en", 32'(wb_en), 0);
        check("R11 wb_sel", 32'(wb_sel), 0);
        check("R11 wb_data", 32'(wb_data), 0);
        check("R11 flags", 32'({flag_c, flag_z}), 0);
        check("R11 product", product, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = VECS[i];
            issue  = 1'b1;
            instr  = v[66:51];
            rd_val = v[50:35];
            rs_val = v[34:19];
            #1;
            check("R1 rd_sel", 32'(rd_sel), 32'(v[61:59]));
            check("R1 rs_sel", 32'(rs_sel), 32'(v[53:51]));
            @(negedge clk);
            check("R2 wb_en", 32'(wb_en), 32'(v[18]));
            if (v[18]) begin
                check("R2 wb_sel", 32'(wb_sel), 32'(v[61:59]));
                check("R2 wb_data", 32'(wb_data), 32'(v[17:2]));
            end
            check("R4 flag_c", 32'(flag_c), 32'(v[1]));
            check("R6 flag_z", 32'(flag_z), 32'(v[0]));
        end
        // flags now C=0 Z=0

        // R8 multiply
        step(1'b1, {5'b11111, 3'd2, 5'b00011, 3'd3}, 16'h1234, 16'h0100);
        check("R8 product", product, 32'h0012_3400);
        check("R8 no write", 32'(wb_en), 0);
        check("R8 flags", 32'({flag_c, flag_z}), 0);
        step(1'b1, {5'b11111, 3'd4, 5'b00011, 3'd5}, 16'hFFFF, 16'hFFFF);
        check("R8 product max", product, 32'hFFFE_0001);

        // R9 load product from s:d
        step(1'b1, {5'b11111, 3'd1, 5'b00101, 3'd0}, 16'hBEEF, 16'hDEAD);
        check("R9 product", product, 32'hDEAD_BEEF);
        check("R9 no write", 32'(wb_en), 0);

        // set Z=1, C=1 so that R10 holds are visible
        step(1'b1, enc_r(3'd2, 3'd0, 3'd1), 16'h0000, 16'h0001);
        step(1'b1, enc_i(3'd4, 3'd0, 7'h00), 16'h0000, 16'h0000);
        check("R10 setup", 32'({flag_c, flag_z}), 32'b11);

        // R10 idle issue with a live-looking word
        step(1'b0, enc_r(3'd0, 3'd1, 3'd2), 16'h0001, 16'h0001);
        check("R10 idle wb_en", 32'(wb_en), 0);
        check("R10 idle flags", 32'({flag_c, flag_z}), 32'b11);
        // R10 out-of-scope words: branch, load, push
        step(1'b1, 16'h9F05, 16'h0001, 16'h0001);
        check("R10 branch wb_en", 32'(wb_en), 0);
        step(1'b1, {5'b11000, 3'd1, 5'b00011, 3'd2}, 16'h0002, 16'h0003);
        check("R10 load wb_en", 32'(wb_en), 0);
        step(1'b1, {5'b11111, 3'd1, 5'b00000, 3'd0}, 16'h0002, 16'h0003);
        check("R10 push wb_en", 32'(wb_en), 0);
        check("R10 flags held", 32'({flag_c, flag_z}), 32'b11);
        check("R10 product held", product, 32'hDEAD_BEEF);

        // R11 reset again clears state
        rst_n = 1'b0;
        #1;
        check("R11 reset clears product", product, 0);
        check("R11 reset clears flags", 32'({flag_c, flag_z}), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule